// File: doc/BRIEF.md
# One-dimensional LED pong controller

This block runs a two-player pong game on a row of LEDs. One lit LED stands for the ball, and it moves one place on each clock. The left player sits at the most significant LED and the right player at the least significant LED. Each player has a press input. The press arrives already captured as a pulse one clock wide, synchronous to the clock. The block handles the serve, ball travel in both directions, a one-cycle dark return window beyond each end LED, penalties for early hits and the short scoring sequence that follows a point.

Every transition, including those caused by presses, is decided in one clocked process. A press is a level sampled at the rising edge, never an asynchronous load. The LED pattern is registered and changes on the same edge as the state. An active-high asynchronous reset returns the game to the left player's serve.

Top module: `led_pong`

## Requirements
- R1: While `rst` is high, and right after it is released, `leds` shows only bit N-1 lit (10000000 for N=8), and the game waits for the left player to serve.
- R2: No more than one bit of `leds` is ever lit.
- R3: In the left serve, `leds` holds bit N-1 until `hit_left` is sampled high at an edge. From that edge on, bits N-2 down to 0 light one per clock.
- R4: If `hit_right` is low in the cycle in which bit 0 is lit, the next cycle is dark (all zero). A `hit_right` sampled in that dark cycle makes the next pattern bit 1, and the ball then climbs one bit per clock.
- R5: If `hit_right` stays low through the dark window, the right serve follows. It shows bit 0 until `hit_right` is sampled, and then bits 1 up to N-1 light one per clock.
- R6: A `hit_right` sampled while bit 0 is lit is an early hit. Bit 0 stays lit for one more cycle, one dark cycle follows, and then the right serve (bit 0) is shown.
- R7: The left end mirrors the right end. After bit N-1 is lit with no `hit_left`, one dark cycle follows. A `hit_left` in that cycle gives bit N-2 next, and no press gives the left serve (bit N-1). A `hit_left` while bit N-1 is lit holds bit N-1 for one cycle, then gives one dark cycle, then the left serve.
- R8: A press from the player who has no move in the current state is ignored. So is any press while the ball is between the end LEDs. The LED sequence goes on exactly as it would without that press.
- R9: When both presses arrive in the same clock, only the press that matters in the current state is acted on, and the other is discarded.
- R10: `leds` is a registered output. A press changes the pattern only after the rising edge that samples it, never before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Game clock; one ball step per rising edge |
| rst | input | 1 | Active-high asynchronous reset |
| hit_left | input | 1 | One-clock press pulse from the player at bit N-1 |
| hit_right | input | 1 | One-clock press pulse from the player at bit 0 |
| leds | output | N | Registered LED pattern, bit N-1 at the left player |

## Verification
The assertions assume that both press inputs are synchronous to `clk`, hold known values whenever reset is low, and are already reduced to single-cycle events. Nothing inside the block filters or stretches them. The bench changes the press inputs only on the falling edge and raises each one for exactly one cycle. It samples `leds` one nanosecond after the rising edge, so each press is seen at exactly one edge. The only input driven asynchronously is reset, in a directed mid-game test, and the clocked properties are disabled while it is high.

// File: rtl/led_pong_pkg.sv
package led_pong_pkg;

  typedef enum logic [3:0] {
    PH_SERVE_L = 4'd0,
    PH_RUN_DN  = 4'd1,
    PH_GAP_R   = 4'd2,
    PH_SERVE_R = 4'd3,
    PH_RUN_UP  = 4'd4,
    PH_GAP_L   = 4'd5,
    PH_HOLD_R  = 4'd6,
    PH_PT_L    = 4'd7,
    PH_HOLD_L  = 4'd8,
    PH_PT_R    = 4'd9
  } phase_t;

endpackage

// File: rtl/led_pong_step.sv
module led_pong_step
  import led_pong_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = $clog2(N)
) (
  input  phase_t          ph,
  input  logic [PW-1:0]   pos,
  input  logic            hit_left,
  input  logic            hit_right,
  output phase_t          ph_nx,
  output logic [PW-1:0]   pos_nx
);

  localparam logic [PW-1:0] POS_TOP  = PW'(N - 1);
  localparam logic [PW-1:0] POS_TOP1 = PW'(N - 2);
  localparam logic [PW-1:0] POS_BOT1 = PW'(1);

  always_comb begin
    ph_nx  = ph;
    pos_nx = pos;
    unique case (ph)
      PH_SERVE_L: if (hit_left) begin
        ph_nx  = PH_RUN_DN;
        pos_nx = POS_TOP1;
      end
      PH_RUN_DN: begin
        if (pos == '0) begin
          ph_nx = hit_right ? PH_HOLD_R : PH_GAP_R;
        end else begin
          pos_nx = pos - 1'b1;
        end
      end
      PH_GAP_R: begin
        if (hit_right) begin
          ph_nx  = PH_RUN_UP;
          pos_nx = POS_BOT1;
        end else begin
          ph_nx = PH_SERVE_R;
        end
      end
      PH_SERVE_R: if (hit_right) begin
        ph_nx  = PH_RUN_UP;
        pos_nx = POS_BOT1;
      end
      PH_RUN_UP: begin
        if (pos == POS_TOP) begin
          ph_nx = hit_left ? PH_HOLD_L : PH_GAP_L;
        end else begin
          pos_nx = pos + 1'b1;
        end
      end
      PH_GAP_L: begin
        if (hit_left) begin
          ph_nx  = PH_RUN_DN;
          pos_nx = POS_TOP1;
        end else begin
          ph_nx = PH_SERVE_L;
        end
      end
      PH_HOLD_R: ph_nx = PH_PT_L;
      PH_PT_L:   ph_nx = PH_SERVE_R;
      PH_HOLD_L: ph_nx = PH_PT_R;
      PH_PT_R:   ph_nx = PH_SERVE_L;
      default:   ph_nx = PH_SERVE_L;
    endcase
  end

endmodule

// File: rtl/led_pong_map.sv
module led_pong_map
  import led_pong_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = $clog2(N)
) (
  input  phase_t        ph,
  input  logic [PW-1:0] pos,
  output logic [N-1:0]  pattern
);

  logic moving;
  logic show_top;
  logic show_bot;

  assign moving   = (ph == PH_RUN_DN) || (ph == PH_RUN_UP);
  assign show_top = (ph == PH_SERVE_L) || (ph == PH_HOLD_L);
  assign show_bot = (ph == PH_SERVE_R) || (ph == PH_HOLD_R);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == N - 1) begin : g_top
      assign pattern[i] = show_top || (moving && pos == PW'(i));
    end else if (i == 0) begin : g_bot
      assign pattern[i] = show_bot || (moving && pos == PW'(i));
    end else begin : g_mid
      assign pattern[i] = moving && pos == PW'(i);
    end
  end

endmodule

// File: rtl/led_pong.sv
module led_pong
  import led_pong_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit_left,
  input  logic         hit_right,
  output logic [N-1:0] leds
);

  localparam int PW = $clog2(N);
  localparam logic [N-1:0] TOP_LED = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] BOT_LED = {{(N-1){1'b0}}, 1'b1};

  phase_t        ph_q, ph_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [N-1:0]  leds_q, leds_d;

  led_pong_step #(.N(N), .PW(PW)) u_step (
    .ph        (ph_q),
    .pos       (pos_q),
    .hit_left  (hit_left),
    .hit_right (hit_right),
    .ph_nx     (ph_d),
    .pos_nx    (pos_d)
  );

  led_pong_map #(.N(N), .PW(PW)) u_map (
    .ph      (ph_d),
    .pos     (pos_d),
    .pattern (leds_d)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ph_q   <= PH_SERVE_L;
      pos_q  <= '0;
      leds_q <= TOP_LED;
    end else begin
      ph_q   <= ph_d;
      pos_q  <= pos_d;
      leds_q <= leds_d;
    end
  end

  assign leds = leds_q;

  // R2: one ball at most
  p_single_ball_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(leds_q));

  // R3: serve waits for the left press
  p_serve_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SERVE_L && !hit_left) |=> (leds_q == TOP_LED && ph_q == PH_SERVE_L));

  // R4: the right window is dark
  p_gap_dark_r4: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_GAP_R) |-> (leds_q == '0));

  // R6: early right hit holds bit 0, then goes dark
  p_early_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_RUN_DN && pos_q == '0 && hit_right) |=> (leds_q == BOT_LED && ph_q == PH_HOLD_R));

  // R6: after the point the right player serves
  p_point_serve_r6: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_PT_L) |=> (ph_q == PH_SERVE_R && leds_q == BOT_LED));

  // R8: mid-flight presses do not disturb the walk
  p_flight_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_RUN_DN && pos_q != '0) |=> (ph_q == PH_RUN_DN && pos_q == $past(pos_q) - 1'b1));

  // R7: the left window is dark
  p_gap_dark_r7: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_GAP_L) |-> (leds_q == '0));

endmodule

// File: tb/led_pong_test.sv
module led_pong_test;

  localparam int N = 8;
  localparam int NV = 58;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hit_left = 1'b0;
  logic hit_right = 1'b0;
  logic [N-1:0] leds;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  led_pong #(.N(N)) uut (
    .clk       (clk),
    .rst       (rst),
    .hit_left  (hit_left),
    .hit_right (hit_right),
    .leds      (leds)
  );

  // {hit_left, hit_right, expected leds after the edge, requirement number}
  // requirement numbers: 3=R3 4=R4 5=R5 6=R6 7=R7 8=R8 9=R9
  localparam logic [13:0] VEC [NV] = '{
    {2'b00, 8'h80, 4'd3}, {2'b01, 8'h80, 4'd8}, {2'b10, 8'h40, 4'd3}, {2'b00, 8'h20, 4'd3},
    {2'b01, 8'h10, 4'd8}, {2'b10, 8'h08, 4'd8}, {2'b00, 8'h04, 4'd3}, {2'b00, 8'h02, 4'd3},
    {2'b00, 8'h01, 4'd3}, {2'b00, 8'h00, 4'd4}, {2'b01, 8'h02, 4'd4}, {2'b00, 8'h04, 4'd4},
    {2'b00, 8'h08, 4'd4}, {2'b00, 8'h10, 4'd4}, {2'b00, 8'h20, 4'd4}, {2'b00, 8'h40, 4'd4},
    {2'b00, 8'h80, 4'd4}, {2'b00, 8'h00, 4'd7}, {2'b11, 8'h40, 4'd9}, {2'b00, 8'h20, 4'd7},
    {2'b00, 8'h10, 4'd7}, {2'b00, 8'h08, 4'd7}, {2'b00, 8'h04, 4'd7}, {2'b00, 8'h02, 4'd7},
    {2'b00, 8'h01, 4'd7}, {2'b11, 8'h01, 4'd9}, {2'b00, 8'h00, 4'd6}, {2'b00, 8'h01, 4'd6},
    {2'b10, 8'h01, 4'd8}, {2'b01, 8'h02, 4'd5}, {2'b00, 8'h04, 4'd5}, {2'b00, 8'h08, 4'd5},
    {2'b00, 8'h10, 4'd5}, {2'b00, 8'h20, 4'd5}, {2'b00, 8'h40, 4'd5}, {2'b00, 8'h80, 4'd5},
    {2'b10, 8'h80, 4'd7}, {2'b00, 8'h00, 4'd7}, {2'b00, 8'h80, 4'd7}, {2'b10, 8'h40, 4'd3},
    {2'b00, 8'h20, 4'd3}, {2'b00, 8'h10, 4'd3}, {2'b00, 8'h08, 4'd3}, {2'b00, 8'h04, 4'd3},
    {2'b00, 8'h02, 4'd3}, {2'b00, 8'h01, 4'd3}, {2'b00, 8'h00, 4'd4}, {2'b00, 8'h01, 4'd5},
    {2'b00, 8'h01, 4'd5}, {2'b01, 8'h02, 4'd5}, {2'b00, 8'h04, 4'd5}, {2'b00, 8'h08, 4'd5},
    {2'b00, 8'h10, 4'd5}, {2'b00, 8'h20, 4'd5}, {2'b00, 8'h40, 4'd5}, {2'b00, 8'h80, 4'd5},
    {2'b00, 8'h00, 4'd7}, {2'b00, 8'h80, 4'd7}
  };

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s leds actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_one_hot(input logic [N-1:0] act);
    n_tests++;
    if ($countones(act) > 1) begin
      n_fail++;
      $display("FAIL R2 leds actual %b expected at most one lit bit", act);
    end
  endtask

  task automatic step(input logic hl, input logic hr);
    @(negedge clk);
    hit_left  = hl;
    hit_right = hr;
    @(posedge clk);
    #1;
    hit_left  = 1'b0;
    hit_right = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, held and after release
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", leds, 8'h80);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after release", leds, 8'h80);

    // main table
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      string tag;
      v = VEC[i];
      step(v[13], v[12]);
      tag = $sformatf("R%0d vector %0d", v[3:0], i);
      check(tag, leds, v[11:4]);
      check_one_hot(leds);
    end

    // R10: a press changes nothing before its sampling edge
    @(negedge clk);
    hit_left = 1'b1;
    #2;
    check("R10 before edge", leds, 8'h80);
    @(posedge clk);
    #1;
    hit_left = 1'b0;
    check("R10 after edge", leds, 8'h40);

    // R1: asynchronous reset mid-flight
    step(1'b0, 1'b0);
    check("R3 mid-flight before reset", leds, 8'h20);
    @(negedge clk);
    #2;
    rst = 1'b1;
    #1;
    check("R1 asynchronous reset", leds, 8'h80);
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0);
    check("R1 serve after reset", leds, 8'h80);
    step(1'b1, 1'b0);
    check("R3 serve after reset", leds, 8'h40);

    finish_run();
  end

endmodule